// File: doc/BRIEF.md
# Serial Link Frame Deserializer

This block sits behind the clock-recovery stage of a serial optical receiver. It samples one recovered data bit on each rising edge of the recovered clock, finds the start of each frame, and turns the bits after the start bit into 16-bit words. Each word goes to an external 18-bit buffer FIFO through an active-low write strobe. A mode input chooses between two frame shapes. The command/reply shape carries an 8-bit preamble and a 24-bit payload after the start bit, and is split into two FIFO entries. The image shape carries one 16-bit pixel after the start bit, and yields one entry.

A link monitor measures how long it has been since the last start bit. It drives a link-good indicator that drops once a programmable number of clock cycles passes with no new frame. The FIFO, the clock recovery and the host-side reader lie outside the block.

Top module: `lnk_deser_top`

## Requirements
- R1: During and right after reset, `fifo_wr_n` is 1, `fifo_data` is 0 and `link_ok` is 0.
- R2: The line idles low. While no frame is in progress, the first sampled 1 is taken as the start bit. A 1 sampled inside a frame is data. No entry is written unless a frame bit was sampled in the previous cycle.
- R3: With `mode_cmd` = 0 (image), the 16 bits that follow the start bit form one entry. They arrive most significant first, so the first bit received lands in `fifo_data[15]` and the last in `fifo_data[0]`.
- R4: With `mode_cmd` = 1 (command/reply), the 32 bits that follow the start bit form two entries. The first entry holds the preamble in bits 15:8 and payload bits 23:16 in bits 7:0. The second entry holds payload bits 15:0.
- R5: `mode_cmd` is sampled only in the start-bit cycle. A change of `mode_cmd` during a frame has no effect on that frame.
- R6: `fifo_wr_n` is 0 for exactly one clock per entry. That clock is the cycle after the edge that samples the entry's last bit, and `fifo_data` holds the entry in that cycle.
- R7: `fifo_data[17:16]` is always 0.
- R8: `link_ok` is 1 in the cycle after a start-bit edge whenever `tmo_lim` is nonzero.
- R9: `link_ok` stays 1 for exactly `tmo_lim` cycles after the most recent start-bit edge, then reads 0 until the next start bit.
- R10: A start bit sampled in the cycle right after the last bit of a frame begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Recovered serial data, one bit per clock |
| mode_cmd | input | 1 | 1 = command/reply frames, 0 = image frames |
| tmo_lim | input | 16 | Link timeout in clock cycles |
| fifo_wr_n | output | 1 | Active-low FIFO write strobe |
| fifo_data | output | 18 | FIFO write data, upper two bits zero |
| link_ok | output | 1 | A start bit was seen within the timeout |

## Verification
A bit counter that is out of step shows up at the ports within one frame. The strobe then fires at the wrong cycle, or a command frame produces one entry instead of two, and the reference model flags this at the first misplaced clock. A shift register that is off by one position corrupts the very next entry, because every data bit is compared against bits computed in the bench. A wrong idle or busy state shows up at the next frame boundary, and a link timer that is off by one shows up as a `link_ok` fall one cycle early or late.

// File: rtl/lnk_deser_pkg.sv
package lnk_deser_pkg;
  typedef enum logic {ST_IDLE, ST_RECV} rx_state_e;

  // number of payload bits following the start bit for a given frame kind
  function automatic int unsigned frame_bits(input logic is_cmd, input int unsigned cmd_len,
                                             input int unsigned img_len);
    return is_cmd ? cmd_len : img_len;
  endfunction

  // true when bit position idx (0-based after start bit) closes a word
  function automatic logic closes_word(input int unsigned idx, input int unsigned word_w);
    return (idx % word_w) == (word_w - 1);
  endfunction
endpackage

// File: rtl/lnk_frame_ctl.sv
module lnk_frame_ctl
  import lnk_deser_pkg::*;
#(
  parameter int unsigned CMD_LEN = 32,
  parameter int unsigned IMG_LEN = 16,
  parameter int unsigned WORD_W  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic mode_cmd,
  output logic start_evt,
  output logic bit_evt,
  output logic word_end,
  output logic frame_end
);
  localparam int unsigned IDX_W = $clog2(CMD_LEN);

  rx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             cmd_q;

  assign start_evt = (state_q == ST_IDLE) && ser_in;
  assign bit_evt   = (state_q == ST_RECV);
  assign word_end  = bit_evt && closes_word(int'(idx_q), WORD_W);
  assign frame_end = bit_evt &&
                     (int'(idx_q) == int'(frame_bits(cmd_q, CMD_LEN, IMG_LEN)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cmd_q   <= 1'b0;
    end else if (start_evt) begin
      state_q <= ST_RECV;
      idx_q   <= '0;
      cmd_q   <= mode_cmd;
    end else if (bit_evt) begin
      idx_q <= idx_q + 1'b1;
      if (frame_end) state_q <= ST_IDLE;
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !bit_evt); // R10
endmodule

// File: rtl/lnk_word_pack.sv
module lnk_word_pack #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FIFO_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              bit_evt,
  input  logic              word_end,
  output logic              wr_n,
  output logic [FIFO_W-1:0] data
);
  localparam int unsigned RSV_W = FIFO_W - WORD_W;

  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      wr_n    <= 1'b1;
      data    <= '0;
    end else begin
      wr_n <= 1'b1;
      if (bit_evt) shreg_q <= {shreg_q[WORD_W-2:0], ser_in};
      if (word_end) begin
        wr_n <= 1'b0;
        data <= {{RSV_W{1'b0}}, shreg_q[WORD_W-2:0], ser_in};
      end
    end
  end
endmodule

// File: rtl/lnk_link_mon.sv
module lnk_link_mon #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic [TMO_W-1:0] tmo_lim,
  output logic             link_ok
);
  logic [TMO_W-1:0] since_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (start_evt) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  assign link_ok = seen_q && (since_q < tmo_lim);

  AST_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && tmo_lim != '0) |=> link_ok); // R8
  AST_LINK_DROP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> !$past(start_evt)); // R9
endmodule

// File: rtl/lnk_deser_top.sv
module lnk_deser_top #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned CMD_W  = 24,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FIFO_W = 18,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              mode_cmd,
  input  logic [TMO_W-1:0]  tmo_lim,
  output logic              fifo_wr_n,
  output logic [FIFO_W-1:0] fifo_data,
  output logic              link_ok
);
  localparam int unsigned CMD_LEN = PRE_W + CMD_W;
  localparam int unsigned IMG_LEN = WORD_W;

  logic start_evt, bit_evt, word_end, frame_end;

  lnk_frame_ctl #(.CMD_LEN(CMD_LEN), .IMG_LEN(IMG_LEN), .WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .mode_cmd(mode_cmd),
    .start_evt(start_evt), .bit_evt(bit_evt), .word_end(word_end), .frame_end(frame_end)
  );

  lnk_word_pack #(.WORD_W(WORD_W), .FIFO_W(FIFO_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .bit_evt(bit_evt),
    .word_end(word_end), .wr_n(fifo_wr_n), .data(fifo_data)
  );

  lnk_link_mon #(.TMO_W(TMO_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .tmo_lim(tmo_lim), .link_ok(link_ok)
  );

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_wr_n |=> fifo_wr_n); // R6
  AST_FRAME_END_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !fifo_wr_n); // R6
  AST_NO_WRITE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_evt |=> fifo_wr_n); // R2
endmodule

// File: tb/tb_lnk_deser_top.sv
module tb_lnk_deser_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_in = 1'b0;
  logic        mode_cmd = 1'b0;
  logic [15:0] tmo_lim = 16'd40;
  logic        fifo_wr_n;
  logic [17:0] fifo_data;
  logic        link_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [17:0] got_q[$];

  lnk_deser_top dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .mode_cmd(mode_cmd), .tmo_lim(tmo_lim),
    .fifo_wr_n(fifo_wr_n), .fifo_data(fifo_data), .link_ok(link_ok)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  bit    m_busy = 0, m_cmd = 0, m_seen = 0;
  int    m_n = 0, m_since = 0;
  logic [15:0] m_word = 0;
  logic        exp_wr_n = 1'b1;
  logic [17:0] exp_data = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_cmd = 0; m_seen = 0; m_n = 0; m_since = 0;
      exp_wr_n = 1'b1; exp_data = '0;
    end else begin
      exp_wr_n = 1'b1;
      if (!m_busy) begin
        if (ser_in) begin
          m_busy = 1; m_cmd = mode_cmd; m_n = 0; m_since = 0; m_seen = 1;
        end else if (m_since < 65535) m_since++;
      end else begin
        m_word = {m_word[14:0], ser_in};
        m_n++;
        if (m_since < 65535) m_since++;
        if (m_n % 16 == 0) begin
          exp_wr_n = 1'b0;
          exp_data = {2'b00, m_word};
        end
        if (m_n == (m_cmd ? 32 : 16)) m_busy = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  string cur_req = "R1";

  // per-clock comparison and FIFO model
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_ok;
      exp_ok = m_seen && (m_since < int'(tmo_lim));
      check(fifo_wr_n === exp_wr_n, "R6 strobe", 32'(fifo_wr_n), 32'(exp_wr_n));
      check(fifo_data === exp_data, cur_req, 32'(fifo_data), 32'(exp_data));
      check(link_ok === exp_ok, "R9 link", 32'(link_ok), 32'(exp_ok));
      if (!fifo_wr_n) got_q.push_back(fifo_data);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic send(input bit cmd, input logic [31:0] bits, input bit flip);
    int n = cmd ? 32 : 16;
    step(); ser_in = 1'b1; mode_cmd = cmd;
    for (int i = n - 1; i >= 0; i--) begin
      step();
      ser_in = bits[i];
      if (flip) mode_cmd = ~cmd;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin step(); ser_in = 1'b0; end
  endtask

  task automatic expect_entry(input string req, input logic [17:0] exp);
    logic [17:0] v;
    if (got_q.size() == 0) begin
      check(1'b0, req, 32'hdead, 32'(exp));
    end else begin
      v = got_q.pop_front();
      check(v === exp, req, 32'(v), 32'(exp));
      check(v[17:16] == 2'b00, "R7", 32'(v[17:16]), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fifo_wr_n === 1'b1 && fifo_data === '0 && link_ok === 1'b0, "R1",
          {13'd0, link_ok, fifo_data}, 32'd0);
    rst_n = 1'b1;
    idle(4);
    // R3 image frame
    cur_req = "R3";
    send(1'b0, 32'h0000A5C3, 1'b0); idle(3);
    expect_entry("R3", 18'h0A5C3);
    // R4 command frame: preamble AC, payload 123456
    cur_req = "R4";
    send(1'b1, 32'hAC123456, 1'b0); idle(3);
    expect_entry("R4", 18'h0AC12);
    expect_entry("R4", 18'h03456);
    // R5 mode changes mid frame
    cur_req = "R5";
    send(1'b0, 32'h00003C0F, 1'b1); idle(3);
    expect_entry("R5", 18'h03C0F);
    check(got_q.size() == 0, "R5 count", 32'(got_q.size()), 32'd0);
    send(1'b1, 32'h53FFFF01, 1'b1); idle(3);
    expect_entry("R5", 18'h053FF);
    expect_entry("R5", 18'h0FF01);
    // R2 R10 all-ones frame then back-to-back frame
    cur_req = "R10";
    send(1'b0, 32'h0000FFFF, 1'b0);
    send(1'b0, 32'h00008001, 1'b0);
    send(1'b1, 32'hFFFFFFFF, 1'b0);
    idle(3);
    expect_entry("R2", 18'h0FFFF);
    expect_entry("R10", 18'h08001);
    expect_entry("R10", 18'h0FFFF);
    expect_entry("R10", 18'h0FFFF);
    // R9 timeout
    cur_req = "R9";
    idle(60);
    check(link_ok === 1'b0, "R9", 32'(link_ok), 32'd0);
    // R8 link comes back one cycle after start edge
    step(); ser_in = 1'b1; mode_cmd = 1'b0;
    step(); ser_in = 1'b0;
    check(link_ok === 1'b1, "R8", 32'(link_ok), 32'd1);
    for (int i = 0; i < 15; i++) begin step(); ser_in = 1'b0; end
    idle(50);
    expect_entry("R8", 18'h00000);
    // shorter timeout
    tmo_lim = 16'd5;
    send(1'b0, 32'h00001234, 1'b0); idle(20);
    expect_entry("R9", 18'h01234);
    check(link_ok === 1'b0, "R9 short", 32'(link_ok), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule